// File: doc/BRIEF.md
# Multi-Lane Pixel Word Deserializer

This block rebuilds a 27-bit parallel pixel word from one, two or three serial lanes. The word holds 24 colour bits (red, green and blue, eight bits each) followed by vertical sync, horizontal sync and data-enable. Every part of the block runs on a single bit-rate clock. The line clock arrives as a sampled level, and each of its rising edges marks the first bit slot of a word. The active lane count is chosen at run time. Each lane carries ceil(27/N) bit slots per word, so a word spans 27, 14 or 9 bit clocks.

The block drives a pixel clock regenerated from the bit-rate clock and a 27-bit output bus. A watchdog counter detects when the line clock stops and drops the block into standby. A receiver-enable input forces shutdown. In both of these states the bus shows a fixed idle pattern. After either state ends, one complete word is thrown away before live data appears. A swap input reverses the order of all 24 colour bits on the bus and leaves the three sync bits where they are.

Top module: `pxd_deserializer`

## Requirements
- R1: The lane count is set by `lane_sel`: 2'b00 gives 1 lane, 2'b01 gives 2 lanes, and 2'b10 or 2'b11 gives 3 lanes. Word bit i (i = 0 is bus bit 26, i = 26 is bus bit 0) travels on lane i mod N in slot i div N. Slot 0 is the bit sampled on the same clock edge that first sees `line_clk` high after it was low.
- R2: The slot count per word is ceil(27/N). Any bit slot whose word index is 27 or more is ignored.
- R3: The bus changes only at the clock edge that samples the last slot of a word. A rising edge of the line clock that arrives before a word is complete restarts framing and discards the partial word.
- R4: With `swap` high, bus[26:3] shows the colour bits in reverse order (bus bit k shows word bit 29-k), so blue, green and red each come out bit-reversed. Bits 2:0 (VS, HS, DE) are unchanged. `swap` acts on the bus with no clock delay.
- R5: `pix_clk` goes high on the edge that loads a word and stays high for floor(ceil(27/N)/2) bit clocks (13, 7 or 4), then low until the next load.
- R6: If 64 bit clocks pass with no line-clock edge, the block enters standby. The bus then shows the idle pattern 27'h7FFFFFE (DE low, all other bits high) and `pix_clk` is low. When edges return, the block leaves standby by itself.
- R7: While `rx_en` is low, the block is in shutdown from the next edge on. It shows the idle pattern and deserializes nothing.
- R8: After standby or shutdown, the first complete word is discarded and the bus stays idle until the following word completes.
- R9: A change of `lane_sel` drops any partly received word. The next word loaded is the first one framed entirely after the change.
- R10: During and right after reset, the bus shows the idle pattern and `pix_clk` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| line_clk | input | 1 | Sampled line clock; its rising edge marks slot 0 |
| lane_data | input | 3 | Serial data lanes, lane 0 in bit 0 |
| lane_sel | input | 2 | Lane count select |
| rx_en | input | 1 | Receiver enable; low forces shutdown |
| swap | input | 1 | Reverse colour-bit order on the bus |
| pix_clk | output | 1 | Regenerated pixel clock |
| pix_bus | output | 27 | Pixel word: colour[26:3], VS[2], HS[1], DE[0] |

## Verification
The last slot of a word is sampled on one rising edge, and the bus and `pix_clk` change on that same edge. The bench therefore drives every slot on a falling edge and reads the outputs on the falling edge after the last slot.

Clock-presence detection adds latency after a stall. It takes one edge to see the restarted line clock and one more to leave standby, so the first word after a stall is lost as well as the warm-up word. After a shutdown with the line clock still running, only the warm-up word is lost. The expected idle and live results are lined up with exactly those words.

The pixel-clock high time is counted over one whole word period. Each sample is taken on a falling edge, before that edge's stimulus is driven. Standby is checked 80 cycles after the clock stops, well past the 64-cycle limit.

// File: rtl/pxd_pkg.sv
package pxd_pkg;

    localparam int WORD_W    = 27;
    localparam int COLOR_W   = 24;
    localparam int MAX_LANES = 3;
    localparam int SLOT_W    = $clog2(WORD_W + 1);
    localparam int NL_W      = $clog2(MAX_LANES + 1);

    typedef logic [WORD_W-1:0] pix_word_t;
    typedef logic [SLOT_W-1:0] slot_t;
    typedef logic [NL_W-1:0]   nlanes_t;

    typedef struct packed {
        logic [COLOR_W-1:0] color;
        logic               vs;
        logic               hs;
        logic               de;
    } pix_fields_t;

    typedef enum logic [1:0] {
        PM_SHUTDOWN = 2'd0,
        PM_STANDBY  = 2'd1,
        PM_WARMUP   = 2'd2,
        PM_ACTIVE   = 2'd3
    } pm_state_t;

    localparam pix_word_t IDLE_WORD = {{(WORD_W-1){1'b1}}, 1'b0};

    function automatic nlanes_t lanes_of(input logic [1:0] sel);
        case (sel)
            2'b00:   return nlanes_t'(1);
            2'b01:   return nlanes_t'(2);
            default: return nlanes_t'(3);
        endcase
    endfunction

    function automatic slot_t slots_of(input nlanes_t n);
        return slot_t'((WORD_W + int'(n) - 1) / int'(n));
    endfunction

    function automatic pix_word_t swap_colors(input pix_word_t w);
        pix_fields_t f;
        pix_fields_t r;
        f = pix_fields_t'(w);
        r = f;
        for (int i = 0; i < COLOR_W; i++) begin
            r.color[i] = f.color[COLOR_W-1-i];
        end
        return pix_word_t'(r);
    endfunction

endpackage

// File: rtl/pxd_clk_monitor.sv
module pxd_clk_monitor #(
    parameter int LOSS_CYCLES = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic line_clk,
    output logic line_rise,
    output logic clk_present
);
    localparam int CNT_W = $clog2(LOSS_CYCLES + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(LOSS_CYCLES - 1);

    logic             lc_q;
    logic [CNT_W-1:0] quiet_cnt;
    logic             lc_edge;

    assign lc_edge   = line_clk ^ lc_q;
    assign line_rise = line_clk & ~lc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lc_q        <= 1'b0;
            quiet_cnt   <= '0;
            clk_present <= 1'b0;
        end else begin
            lc_q <= line_clk;
            if (lc_edge) begin
                quiet_cnt   <= '0;
                clk_present <= 1'b1;
            end else if (quiet_cnt == LIMIT) begin
                clk_present <= 1'b0;
            end else begin
                quiet_cnt <= quiet_cnt + 1'b1;
            end
        end
    end

    AST_PRESENT_AFTER_EDGE: assert property (@(posedge clk) disable iff (rst)
        (line_clk != lc_q) |=> clk_present);  // R6

endmodule

// File: rtl/pxd_lane_framer.sv
module pxd_lane_framer
    import pxd_pkg::*;
#(
    parameter int LANES = MAX_LANES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             line_rise,
    input  logic [1:0]       lane_sel,
    input  logic [LANES-1:0] lane_data,
    output logic             word_done,
    output pix_word_t        word_bits
);
    nlanes_t    nl;
    slot_t      bpl;
    slot_t      slot;
    slot_t      cur_slot;
    logic       busy;
    logic       take;
    logic       sel_chg;
    logic [1:0] sel_q;
    pix_word_t  acc;
    pix_word_t  acc_next;

    always_comb begin
        nl       = lanes_of(lane_sel);
        bpl      = slots_of(nl);
        sel_chg  = (lane_sel != sel_q);
        take     = en && !sel_chg && (line_rise || busy);
        cur_slot = line_rise ? '0 : slot;
        acc_next = acc;
        for (int l = 0; l < LANES; l++) begin
            int idx;
            idx = int'(cur_slot) * int'(nl) + l;
            if (take && (l < int'(nl)) && (idx < WORD_W)) begin
                acc_next[WORD_W-1-idx] = lane_data[l];
            end
        end
        word_done = take && (cur_slot == bpl - 1'b1);
        word_bits = acc_next;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            slot  <= '0;
            acc   <= '0;
            sel_q <= lane_sel;
        end else begin
            sel_q <= lane_sel;
            acc   <= acc_next;
            if (!en || sel_chg) begin
                busy <= 1'b0;
                slot <= '0;
            end else if (take) begin
                busy <= !word_done;
                slot <= cur_slot + 1'b1;
            end
        end
    end

    AST_SLOT_BOUND: assert property (@(posedge clk) disable iff (rst)
        busy |-> (slot < bpl));  // R2

    AST_RISE_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        (en && line_rise && !sel_chg && (bpl > slot_t'(1))) |=> (busy && slot == slot_t'(1)));  // R3

endmodule

// File: rtl/pxd_power_ctrl.sv
module pxd_power_ctrl
    import pxd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      rx_en,
    input  logic      clk_present,
    input  logic      word_done,
    output pm_state_t state,
    output logic      load
);
    pm_state_t state_nx;

    always_comb begin
        state_nx = state;
        if (!rx_en) begin
            state_nx = PM_SHUTDOWN;
        end else if (!clk_present) begin
            state_nx = PM_STANDBY;
        end else begin
            case (state)
                PM_SHUTDOWN, PM_STANDBY: state_nx = PM_WARMUP;
                PM_WARMUP:               state_nx = word_done ? PM_ACTIVE : PM_WARMUP;
                default:                 state_nx = PM_ACTIVE;
            endcase
        end
    end

    assign load = word_done && (state == PM_ACTIVE);

    always_ff @(posedge clk) begin
        if (rst) state <= PM_SHUTDOWN;
        else     state <= state_nx;
    end

    AST_SHUTDOWN_ON_DISABLE: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> (state == PM_SHUTDOWN));  // R7

    AST_WARMUP_BEFORE_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        (state == PM_ACTIVE && $past(state) != PM_ACTIVE) |-> ($past(state) == PM_WARMUP));  // R8

endmodule

// File: rtl/pxd_deserializer.sv
module pxd_deserializer
    import pxd_pkg::*;
#(
    parameter int LOSS_CYCLES = 64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 line_clk,
    input  logic [MAX_LANES-1:0] lane_data,
    input  logic [1:0]           lane_sel,
    input  logic                 rx_en,
    input  logic                 swap,
    output logic                 pix_clk,
    output logic [WORD_W-1:0]    pix_bus
);
    logic      line_rise;
    logic      clk_present;
    logic      word_done;
    logic      load;
    logic      framer_en;
    logic      shown;
    logic      showing;
    pix_word_t word_bits;
    pix_word_t word_q;
    pm_state_t state;
    slot_t     pclk_cnt;
    slot_t     half;

    pxd_clk_monitor #(.LOSS_CYCLES(LOSS_CYCLES)) u_mon (
        .clk         (clk),
        .rst         (rst),
        .line_clk    (line_clk),
        .line_rise   (line_rise),
        .clk_present (clk_present)
    );

    assign framer_en = (state == PM_WARMUP) || (state == PM_ACTIVE);

    pxd_lane_framer #(.LANES(MAX_LANES)) u_frm (
        .clk       (clk),
        .rst       (rst),
        .en        (framer_en),
        .line_rise (line_rise),
        .lane_sel  (lane_sel),
        .lane_data (lane_data),
        .word_done (word_done),
        .word_bits (word_bits)
    );

    pxd_power_ctrl u_pm (
        .clk         (clk),
        .rst         (rst),
        .rx_en       (rx_en),
        .clk_present (clk_present),
        .word_done   (word_done),
        .state       (state),
        .load        (load)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q   <= '0;
            shown    <= 1'b0;
            pclk_cnt <= '1;
        end else begin
            if (load) begin
                word_q   <= word_bits;
                pclk_cnt <= '0;
            end else if (pclk_cnt != '1) begin
                pclk_cnt <= pclk_cnt + 1'b1;
            end
            if (state != PM_ACTIVE) shown <= 1'b0;
            else if (load)          shown <= 1'b1;
        end
    end

    always_comb begin
        half    = slots_of(lanes_of(lane_sel)) >> 1;
        showing = shown && (state == PM_ACTIVE);
        pix_clk = showing && (pclk_cnt < half);
        if (!showing)  pix_bus = IDLE_WORD;
        else if (swap) pix_bus = swap_colors(word_q);
        else           pix_bus = word_q;
    end

    AST_LOAD_ON_DONE: assert property (@(posedge clk) disable iff (rst)
        !$stable(word_q) |-> $past(load));  // R3

    AST_IDLE_WHEN_DISABLED: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> (pix_bus == IDLE_WORD && !pix_clk));  // R7

    AST_LANE_CHANGE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$stable(lane_sel) |=> $stable(word_q));  // R9

endmodule

// File: tb/pxd_deserializer_test.sv
module pxd_deserializer_test;

    localparam logic [26:0] IDLE = 27'h7FFFFFE;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        line_clk = 1'b0;
    logic [2:0]  lane_data = '0;
    logic [1:0]  lane_sel = 2'b00;
    logic        rx_en = 1'b1;
    logic        swap = 1'b0;
    logic        pix_clk;
    logic [26:0] pix_bus;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    pxd_deserializer uut (
        .clk       (clk),
        .rst       (rst),
        .line_clk  (line_clk),
        .lane_data (lane_data),
        .lane_sel  (lane_sel),
        .rx_en     (rx_en),
        .swap      (swap),
        .pix_clk   (pix_clk),
        .pix_bus   (pix_bus)
    );

    always #4 clk = ~clk;

    function automatic logic [26:0] exp_swap(input logic [26:0] w);
        logic [26:0] r;
        r = w;
        for (int k = 3; k < 27; k++) r[k] = w[29-k];
        return r;
    endfunction

    task automatic chk(input string req, input logic [26:0] act, input logic [26:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_slots(input logic [26:0] w, input int n, input int first,
                              input int last, input int hi_slots, input logic junk,
                              output int hi);
        hi = 0;
        for (int s = first; s <= last; s++) begin
            @(negedge clk);
            if (pix_clk) hi++;
            line_clk = (s < hi_slots);
            for (int l = 0; l < 3; l++) begin
                int idx = s * n + l;
                if (l >= n)        lane_data[l] = 1'b0;
                else if (idx < 27) lane_data[l] = w[26-idx];
                else               lane_data[l] = junk;
            end
        end
    endtask

    task automatic send_word(input logic [26:0] w, input int n, input logic junk, output int hi);
        int bpl = (27 + n - 1) / n;
        send_slots(w, n, 0, bpl - 1, (bpl + 1) / 2, junk, hi);
        @(negedge clk);
        line_clk  = 1'b0;
        lane_data = '0;
    endtask

    task automatic t_reset();
        repeat (4) @(negedge clk);
        chk("R10 bus in reset", pix_bus, IDLE);
        chk("R10 pix_clk in reset", {26'd0, pix_clk}, 27'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 bus after reset", pix_bus, IDLE);
    endtask

    task automatic t_startup_one_lane();
        int hi;
        int p0;
        send_word(27'h1234567, 1, 1'b0, hi);
        chk("R8 word lost while detecting clock", pix_bus, IDLE);
        send_word(27'h2ABCDEF, 1, 1'b0, hi);
        chk("R8 warm-up word discarded", pix_bus, IDLE);
        send_word(27'h5A5A5A5, 1, 1'b0, hi);
        chk("R1 one-lane word", pix_bus, 27'h5A5A5A5);
        p0 = pix_clk ? 1 : 0;
        chk("R5 pix_clk high on load", {26'd0, pix_clk}, 27'd1);
        send_word(27'h3C0FF0C, 1, 1'b0, hi);
        chk("R5 pix_clk high cycles 1 lane", 27'(p0 + hi), 27'd13);
        chk("R1 second one-lane word", pix_bus, 27'h3C0FF0C);
    endtask

    task automatic t_swap();
        int hi;
        swap = 1'b1;
        send_word(27'h6C3A5F1, 1, 1'b0, hi);
        chk("R4 swapped bus", pix_bus, exp_swap(27'h6C3A5F1));
        swap = 1'b0;
        #1;
        chk("R4 swap released", pix_bus, 27'h6C3A5F1);
    endtask

    task automatic t_two_lanes();
        int hi;
        int p0;
        lane_sel = 2'b01;
        send_word(27'h0F1E2D3, 2, 1'b1, hi);
        chk("R2 two lanes, trailing slot high", pix_bus, 27'h0F1E2D3);
        p0 = pix_clk ? 1 : 0;
        send_word(27'h7654321, 2, 1'b0, hi);
        chk("R1 two-lane word", pix_bus, 27'h7654321);
        chk("R5 pix_clk high cycles 2 lanes", 27'(p0 + hi), 27'd7);
    endtask

    task automatic t_three_lanes();
        int hi;
        int p0;
        lane_sel = 2'b10;
        send_word(27'h4B2D1E8, 3, 1'b0, hi);
        chk("R1 three-lane word", pix_bus, 27'h4B2D1E8);
        p0 = pix_clk ? 1 : 0;
        send_word(27'h19A7C3E, 3, 1'b0, hi);
        chk("R5 pix_clk high cycles 3 lanes", 27'(p0 + hi), 27'd4);
        chk("R1 three-lane word 2", pix_bus, 27'h19A7C3E);
    endtask

    task automatic t_restart();
        int hi;
        send_slots(27'h7FFFFFF, 3, 0, 4, 2, 1'b0, hi);
        @(negedge clk);
        line_clk = 1'b0;
        chk("R3 partial word not shown", pix_bus, 27'h19A7C3E);
        send_word(27'h2468ACE, 3, 1'b0, hi);
        chk("R3 early rise restarts framing", pix_bus, 27'h2468ACE);
    endtask

    task automatic t_lane_change();
        int hi;
        send_slots(27'h5555555, 3, 0, 4, 2, 1'b0, hi);
        lane_sel = 2'b01;
        send_slots(27'h5555555, 3, 5, 8, 0, 1'b0, hi);
        @(negedge clk);
        chk("R9 partial word dropped on lane change", pix_bus, 27'h2468ACE);
        send_word(27'h13579BD, 2, 1'b0, hi);
        chk("R9 word after lane change", pix_bus, 27'h13579BD);
    endtask

    task automatic t_standby();
        int hi;
        line_clk = 1'b0;
        repeat (80) @(negedge clk);
        chk("R6 idle bus in standby", pix_bus, IDLE);
        chk("R6 pix_clk low in standby", {26'd0, pix_clk}, 27'd0);
        send_word(27'h0000001, 2, 1'b0, hi);
        chk("R8 first word after standby", pix_bus, IDLE);
        send_word(27'h0000002, 2, 1'b0, hi);
        chk("R8 warm-up word after standby", pix_bus, IDLE);
        send_word(27'h3E1F0A5, 2, 1'b0, hi);
        chk("R6 live after clock returns", pix_bus, 27'h3E1F0A5);
    endtask

    task automatic t_shutdown();
        int hi;
        rx_en = 1'b0;
        send_word(27'h6666666, 2, 1'b0, hi);
        chk("R7 idle bus in shutdown", pix_bus, IDLE);
        chk("R7 pix_clk low in shutdown", {26'd0, pix_clk}, 27'd0);
        rx_en = 1'b1;
        send_word(27'h1111111, 2, 1'b0, hi);
        chk("R8 warm-up word after shutdown", pix_bus, IDLE);
        send_word(27'h2C4E6A8, 2, 1'b0, hi);
        chk("R7 live after enable", pix_bus, 27'h2C4E6A8);
    endtask

    initial begin
        t_reset();
        t_startup_one_lane();
        t_swap();
        t_two_lanes();
        t_three_lanes();
        t_restart();
        t_lane_change();
        t_standby();
        t_shutdown();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

endmodule